// File: doc/BRIEF.md
# Attribute Register File with Shared Index/Data Port

This block holds the 21 byte-wide attribute registers of a display controller. A host reaches them over a byte-wide bus that selects one of four small ports with a 2-bit port number. Index and data share one write port, and a hidden phase bit decides which one a write lands in. The first write after the phase is cleared loads the index. The next write goes to the register that index selects. Every write to that port flips the phase. A separate readback port returns the selected register. A status port returns a byte whose retrace and display-enable bits change on every read. Reading the status port also clears the phase, so software can always find a known starting point.

The bus uses plain strobes and has no back-pressure. A write takes effect at the clock edge where `wr_stb` is high. A read strobe is answered on the next cycle by `rd_valid` together with `rdata`. The host may never raise `rd_stb` and `wr_stb` in the same cycle. Each write keeps only the bits that the target register defines. Undefined bits always read back as zero.

Top module: `attr_regfile`

## Requirements
- R1: After reset the phase bit is 0, the index is 0, all 21 registers are 0, the status byte is 0, and `rd_valid` and `rdata` are 0.
- R2: A write to port 0 while the phase is 0 stores `wdata[5:0]` as the index and sets the phase to 1. The upper two bits are dropped.
- R3: A write to port 0 while the phase is 1 stores the data into the register chosen by index bits [4:0]. It leaves the index unchanged and returns the phase to 0.
- R4: Registers keep only these bits of the written data: slots 0 to 15 keep 0x3F, slot 16 keeps 0xEF, slot 17 keeps 0xFF, slot 18 keeps 0x3F, and slots 19 and 20 keep 0x0F.
- R5: A data-phase write whose index bits [4:0] are 21 or more changes no register, but it still flips the phase.
- R6: A read of port 0 returns the index, zero-extended, when the phase is 0. It returns 0 when the phase is 1. It changes nothing.
- R7: A read of port 1 returns the register chosen by index bits [4:0], or 0 when that value is 21 or more.
- R8: A read of port 2 inverts bit 3 and bit 0 of the status byte, returns the new byte, and clears the phase.
- R9: `rd_valid` is high exactly in the cycle after a read strobe, and `rdata` is 0 in any other cycle. Reads and writes never share a cycle.
- R10: Writes to ports 1, 2 and 3 change no state, and a read of port 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 2 | Port number: 0 index/data, 1 register readback, 2 status, 3 spare |
| wr_stb | input | 1 | Write strobe, one write per cycle high |
| wdata | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe, answered next cycle |
| rdata | output | 8 | Read result, valid when `rd_valid` is high |
| rd_valid | output | 1 | Marks the cycle that carries a read result |

## Verification
The bench sweeps all 64 index values with four data patterns. This exposes a wrong per-slot mask, which would leave stray high bits. It also exposes use of six index bits instead of five for slot selection, which would alias or drop slots. It catches a write to slots 21 to 31 that lands somewhere, and a phase that fails to flip on an ignored write, which would shift every later access by one. The phase is cleared by a status read in the middle of a pair. A design that keeps the old phase would store the next byte as data rather than as the index. The bench also checks that writes to the read-only ports change no state. It checks that the status byte returns its new, toggled value; a design that returned the old value would read one step behind.

// File: rtl/attr_pkg.sv
`timescale 1ns/1ps
package attr_pkg;
  localparam int ATTR_DW    = 8;
  localparam int ATTR_IDX_W = 6;
  localparam int ATTR_SEL_W = 5;
  localparam int ATTR_SLOTS = 21;

  typedef enum logic [1:0] {
    PORT_IDXDATA = 2'd0,
    PORT_READBK  = 2'd1,
    PORT_STATUS  = 2'd2,
    PORT_SPARE   = 2'd3
  } port_e;

  // Bits a slot retains on write; unlisted slots retain nothing.
  function automatic logic [ATTR_DW-1:0] slot_keep(input int unsigned n);
    if (n < 16)                 return 8'h3F;
    else if (n == 16)           return 8'hEF;
    else if (n == 17)           return 8'hFF;
    else if (n == 18)           return 8'h3F;
    else if (n == 19 || n == 20) return 8'h0F;
    else                        return 8'h00;
  endfunction
endpackage

// File: rtl/attr_phase_ctl.sv
`timescale 1ns/1ps
module attr_phase_ctl #(
  parameter int DW    = attr_pkg::ATTR_DW,
  parameter int IDX_W = attr_pkg::ATTR_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shared_wr,
  input  logic [DW-1:0]    wdata,
  input  logic             phase_clr,
  output logic             phase_q,
  output logic [IDX_W-1:0] index_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      index_q <= '0;
    end else begin
      if (shared_wr && !phase_q) index_q <= wdata[IDX_W-1:0];
      if (phase_clr)             phase_q <= 1'b0;
      else if (shared_wr)        phase_q <= ~phase_q;
    end
  end

  p_clear_on_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> !phase_q);
  p_index_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_wr && phase_q) |=> $stable(index_q));
  p_index_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_wr && !phase_q && !phase_clr) |=> phase_q);
endmodule

// File: rtl/attr_slot_store.sv
`timescale 1ns/1ps
module attr_slot_store #(
  parameter int DW    = attr_pkg::ATTR_DW,
  parameter int SEL_W = attr_pkg::ATTR_SEL_W,
  parameter int SLOTS = attr_pkg::ATTR_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_word
);
  logic [DW-1:0] slot_q [SLOTS];
  logic          in_range;

  assign in_range = (32'(sel) < SLOTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (data_wr && in_range) begin
      for (int i = 0; i < SLOTS; i++)
        if (32'(sel) == i) slot_q[i] <= wdata & DW'(attr_pkg::slot_keep(i));
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < SLOTS; i++)
      if (32'(sel) == i) rd_word = slot_q[i];
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_chk
    localparam logic [DW-1:0] KEEP = DW'(attr_pkg::slot_keep(g));
    p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_q[g] & ~KEEP) == '0);
    p_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(data_wr && 32'(sel) == g) |=> $stable(slot_q[g]));
  end
endmodule

// File: rtl/attr_status.sv
`timescale 1ns/1ps
module attr_status #(
  parameter int DW     = attr_pkg::ATTR_DW,
  parameter int VR_BIT = 3,
  parameter int DE_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_read,
  output logic [DW-1:0] st_next
);
  localparam logic [DW-1:0] FLIP = (DW'(1) << VR_BIT) | (DW'(1) << DE_BIT);
  logic [DW-1:0] st_q;

  assign st_next = st_q ^ FLIP;

  always_ff @(posedge clk) begin
    if (!rst_n)       st_q <= '0;
    else if (st_read) st_q <= st_next;
  end

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_read |=> $stable(st_q));
  p_status_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_read |=> (st_q[VR_BIT] != $past(st_q[VR_BIT])) && (st_q[DE_BIT] != $past(st_q[DE_BIT])));
endmodule

// File: rtl/attr_regfile.sv
`timescale 1ns/1ps
module attr_regfile #(
  parameter int DW    = attr_pkg::ATTR_DW,
  parameter int IDX_W = attr_pkg::ATTR_IDX_W,
  parameter int SEL_W = attr_pkg::ATTR_SEL_W,
  parameter int SLOTS = attr_pkg::ATTR_SLOTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    port_sel,
  input  logic          wr_stb,
  input  logic [DW-1:0] wdata,
  input  logic          rd_stb,
  output logic [DW-1:0] rdata,
  output logic          rd_valid
);
  import attr_pkg::*;

  port_e             port;
  logic              phase;
  logic [IDX_W-1:0]  index;
  logic [DW-1:0]     slot_word;
  logic [DW-1:0]     st_next;
  logic              shared_wr;
  logic              st_read;

  assign port      = port_e'(port_sel);
  assign shared_wr = wr_stb && (port == PORT_IDXDATA);
  assign st_read   = rd_stb && (port == PORT_STATUS);

  attr_phase_ctl #(.DW(DW), .IDX_W(IDX_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .shared_wr(shared_wr), .wdata(wdata),
    .phase_clr(st_read), .phase_q(phase), .index_q(index)
  );

  attr_slot_store #(.DW(DW), .SEL_W(SEL_W), .SLOTS(SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .data_wr(shared_wr && phase),
    .sel(index[SEL_W-1:0]), .wdata(wdata), .rd_word(slot_word)
  );

  attr_status #(.DW(DW)) u_status (
    .clk(clk), .rst_n(rst_n), .st_read(st_read), .st_next(st_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        unique case (port)
          PORT_IDXDATA: rdata <= phase ? '0 : DW'(index);
          PORT_READBK:  rdata <= slot_word;
          PORT_STATUS:  rdata <= st_next;
          default:      rdata <= '0;
        endcase
      end else begin
        rdata <= '0;
      end
    end
  end

  p_no_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (!rd_valid && rdata == '0));
  p_phase1_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && port == PORT_IDXDATA && phase) |=> rdata == '0);
  p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && port == PORT_SPARE) |=> rdata == '0);
  p_far_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && port == PORT_READBK && 32'(index[SEL_W-1:0]) >= SLOTS) |=> rdata == '0);
endmodule

// File: tb/sim_attr_regfile.sv
`timescale 1ns/1ps
module sim_attr_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] port_sel = 2'd0;
  logic       wr_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       rd_stb = 1'b0;
  logic [7:0] rdata;
  logic       rd_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_slot [32];
  logic [5:0] m_idx;
  logic       m_ph;
  logic [7:0] m_st;

  always #2.5 clk = ~clk;

  attr_regfile u0 (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_stb(wr_stb),
    .wdata(wdata), .rd_stb(rd_stb), .rdata(rdata), .rd_valid(rd_valid)
  );

  function automatic logic [7:0] keep_of(input int n);
    if (n <= 15) return 8'h3F;
    case (n)
      16: return 8'hEF;
      17: return 8'hFF;
      18: return 8'h3F;
      19, 20: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input int p, input logic [7:0] d);
    @(negedge clk);
    port_sel = 2'(p); wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (p == 0) begin
      if (!m_ph) m_idx = d[5:0];
      else if (m_idx[4:0] < 21) m_slot[m_idx[4:0]] = d & keep_of(int'(m_idx[4:0]));
      m_ph = ~m_ph;
    end
  endtask

  task automatic do_rd(input int p, input string tag);
    logic [7:0] exp;
    case (p)
      0: exp = m_ph ? 8'h00 : {2'b00, m_idx};
      1: exp = (m_idx[4:0] < 21) ? m_slot[m_idx[4:0]] : 8'h00;
      2: begin m_st = m_st ^ 8'h09; m_ph = 1'b0; exp = m_st; end
      default: exp = 8'h00;
    endcase
    @(negedge clk);
    port_sel = 2'(p); rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    check("R9 valid", {7'd0, rd_valid}, 8'h01);
    check(tag, rdata, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) m_slot[i] = 8'h00;
    m_idx = 6'd0; m_ph = 1'b0; m_st = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet outputs after reset
    check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    do_rd(0, "R1 index");
    for (int i = 0; i < 21; i++) begin
      do_wr(0, 8'(i));
      do_rd(1, "R1 slot");
      do_rd(2, "R1 R8 status");
    end
    // idle cycle: rdata returns to 0 (R9)
    @(negedge clk);
    check("R9 idle valid", {7'd0, rd_valid}, 8'h00);
    check("R9 idle rdata", rdata, 8'h00);

    // sweep all index values and several patterns (R2..R7)
    for (int idx = 0; idx < 64; idx++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] pat;
        case (k)
          0: pat = 8'hFF;
          1: pat = 8'hA5;
          2: pat = 8'h5A;
          default: pat = 8'(idx * 7 + 3);
        endcase
        do_wr(0, {2'b11, 6'(idx)});            // upper bits dropped, R2
        do_rd(0, "R2 index");
        do_wr(0, pat);                         // data phase, R3 R4 R5
        do_rd(0, "R3 R5 phase back to 0");
        do_wr(0, 8'(idx));
        do_rd(0, "R6 phase1 reads 0");
        do_rd(1, (idx % 32) < 21 ? "R4 R7 slot" : "R5 R7 far slot");
        do_rd(2, "R8 status");
      end
    end

    // R8: status read mid-pair restarts the phase
    do_wr(0, 8'h05);
    do_rd(2, "R8 clear");
    do_wr(0, 8'h12);
    do_rd(0, "R8 new index");
    do_wr(0, 8'hFF);
    do_rd(1, "R8 R4 slot18");

    // R10: writes to other ports change nothing
    do_wr(0, 8'h11);
    do_wr(0, 8'h5C);
    do_wr(0, 8'h03);
    do_wr(1, 8'hFF);
    do_wr(2, 8'hFF);
    do_wr(3, 8'hFF);
    do_rd(0, "R10 phase and index kept");
    do_wr(0, 8'h03);
    do_rd(1, "R10 slot kept");
    do_rd(2, "R10 status kept");
    do_rd(3, "R10 spare reads 0");
    do_wr(0, 8'h11);
    do_rd(1, "R10 slot17 kept");

    finish_run();
  end
endmodule